// File: doc/BRIEF.md
# Step-Programmable Timestamp Counter with Snapshot

This block is the time base of a system timer. A 64-bit counter runs freely and, on each clock where counting is enabled, adds a programmable step. Two step values are held, one for a fast PLL-derived clock and one for a slower crystal-derived clock. The `src_slow` input says which source is active, and that source's step is the one added. With the reset steps of 1 at 80 MHz and 2 at 40 MHz, the count advances by 80 per microsecond on either source.

Software reaches the block through a simple write port with four word addresses. It reads the count through a snapshot: a request copies the live count into a pair of 32-bit read halves, and a valid flag says when those halves may be read. A new count is loaded in two stages. Two staging words are written first, and a separate apply pulse then moves the staged value into the counter.

Top module: `tsc_top`

## Requirements
- R1: After reset the counter is 0, counting is disabled, the fast step is 1, the slow step is 2, `snap_lo` and `snap_hi` are 0 and `snap_valid` is 0.
- R2: Writes are sampled on a rising edge of `clk` while `wr_en` is 1. The address map is 0 = control, 1 = step, 2 = load low word, 3 = load high word. A control write stores bit 0 as the run enable. In the same write, bit 1 requests a snapshot and bit 2 requests an apply.
- R3: While the run enable is 1 and `src_slow` is 0, each rising edge with no apply adds the fast step to the counter.
- R4: While the run enable is 1 and `src_slow` is 1, each rising edge with no apply adds the slow step to the counter.
- R5: While the run enable is 0, the counter holds its value unless an apply occurs.
- R6: A step write takes the fast step from bits [9:0] and the slow step from bits [25:16]. Each step is zero-extended before it is added.
- R7: On the edge that samples a snapshot request, the counter value present before that edge is copied into {`snap_hi`,`snap_lo`}. `snap_lo` holds bits [31:0] and `snap_hi` holds bits [63:32].
- R8: `snap_valid` is 0 in the cycle after a snapshot request edge. It is 1 from the cycle after that onward, until the next request.
- R9: `snap_lo` and `snap_hi` change only on a snapshot request edge.
- R10: Writes to the load words change the counter only when an apply is sampled. On that edge the counter takes exactly {load high, load low}: no step is added, and the run enable does not matter.
- R11: The counter wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| src_slow | input | 1 | 1 = crystal-derived source active, 0 = PLL-derived source active |
| snap_lo | output | 32 | Snapshot, low word |
| snap_hi | output | 32 | Snapshot, high word |
| snap_valid | output | 1 | Snapshot halves hold the latest requested value |

## Verification
The properties assume that `src_slow` and the write port change only between clock edges, and that exactly one write is presented per sampled strobe. The stimulus drives every input on the falling edge and holds it through the next rising edge. It inserts an idle cycle after every write, so each request is seen on exactly one edge. A behavioural model predicts the snapshot outputs every cycle. Hand-computed values cover the apply-versus-step priority and the 64-bit wrap.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_CTRL  = 2'd0,
      REG_STEP  = 2'd1,
      REG_LD_LO = 2'd2,
      REG_LD_HI = 2'd3
   } reg_addr_e;

   localparam int CTRL_RUN_BIT   = 0;
   localparam int CTRL_SNAP_BIT  = 1;
   localparam int CTRL_APPLY_BIT = 2;
   localparam int STEP_SLOW_LSB  = 16;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
   import tsc_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 64,
   parameter int STEP_W   = 10,
   parameter int RST_FAST = 1,
   parameter int RST_SLOW = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              run_en,
   output logic              snap_req,
   output logic              apply_req,
   output logic [STEP_W-1:0] step_fast,
   output logic [STEP_W-1:0] step_slow,
   output logic [CNT_W-1:0]  load_val
);
   localparam int NHALF = CNT_W / DATA_W;

   logic hit_ctrl, hit_step;
   logic run_q;
   logic [STEP_W-1:0] fast_q, slow_q;

   assign hit_ctrl = wr_en && (wr_addr == REG_CTRL);
   assign hit_step = wr_en && (wr_addr == REG_STEP);

   assign snap_req  = hit_ctrl && wr_data[CTRL_SNAP_BIT];
   assign apply_req = hit_ctrl && wr_data[CTRL_APPLY_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (hit_ctrl) begin
         run_q <= wr_data[CTRL_RUN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q <= STEP_W'(RST_FAST);
         slow_q <= STEP_W'(RST_SLOW);
      end else if (hit_step) begin
         fast_q <= wr_data[STEP_W-1:0];
         slow_q <= wr_data[STEP_SLOW_LSB +: STEP_W];
      end
   end

   for (genvar g = 0; g < NHALF; g++) begin : g_stage
      logic [DATA_W-1:0] half_q;
      logic              hit_half;
      assign hit_half = wr_en && (wr_addr == ADDR_W'(int'(REG_LD_LO) + g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_q <= '0;
         end else if (hit_half) begin
            half_q <= wr_data;
         end
      end
      assign load_val[g*DATA_W +: DATA_W] = half_q;
   end

   assign run_en    = run_q;
   assign step_fast = fast_q;
   assign step_slow = slow_q;
endmodule

// File: rtl/tsc_count.sv
module tsc_count #(
   parameter int CNT_W     = 64,
   parameter int STEP_W    = 10,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              src_slow,
   input  logic [STEP_W-1:0] step_fast,
   input  logic [STEP_W-1:0] step_slow,
   input  logic              apply_req,
   input  logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  cnt
);
   localparam int PAD_W = CNT_W - STEP_W;

   logic [CNT_W-1:0] cnt_q, step_ext, sum;
   logic [STEP_W-1:0] step_sel;

   assign step_sel = src_slow ? step_slow : step_fast;
   assign step_ext = {{PAD_W{1'b0}}, step_sel};

   if (SPLIT_ADD) begin : g_split
      localparam int LO_W = CNT_W / 2;
      localparam int HI_W = CNT_W - LO_W;
      logic [LO_W:0]   lo_sum;
      logic [HI_W-1:0] hi_sum;
      assign lo_sum = {1'b0, cnt_q[LO_W-1:0]} + {1'b0, step_ext[LO_W-1:0]};
      assign hi_sum = cnt_q[CNT_W-1:LO_W] + step_ext[CNT_W-1:LO_W] + HI_W'(lo_sum[LO_W]);
      assign sum    = {hi_sum, lo_sum[LO_W-1:0]};
   end else begin : g_flat
      assign sum = cnt_q + step_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (apply_req) begin
         cnt_q <= load_val;
      end else if (run_en) begin
         cnt_q <= sum;
      end
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/tsc_snap.sv
module tsc_snap #(
   parameter int CNT_W  = 64,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_req,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] snap_lo,
   output logic [DATA_W-1:0] snap_hi,
   output logic              snap_valid
);
   logic [CNT_W-1:0] hold_q;
   logic             pend_q, valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (snap_req) begin
         hold_q <= cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         pend_q  <= snap_req;
         valid_q <= !snap_req && (pend_q || valid_q);
      end
   end

   assign snap_lo    = hold_q[DATA_W-1:0];
   assign snap_hi    = hold_q[CNT_W-1:DATA_W];
   assign snap_valid = valid_q;
endmodule

// File: rtl/tsc_top.sv
module tsc_top
   import tsc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 64,
   parameter int STEP_W    = 10,
   parameter int RST_FAST  = 1,
   parameter int RST_SLOW  = 2,
   parameter bit SPLIT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              src_slow,
   output logic [31:0]       snap_lo,
   output logic [31:0]       snap_hi,
   output logic              snap_valid
);
   if (CNT_W != 2 * DATA_W) begin : g_bad_width
      $error("tsc_top: CNT_W must be twice DATA_W");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("tsc_top: port widths assume DATA_W of 32");
   end
   if (STEP_W < 1 || STEP_W > STEP_SLOW_LSB) begin : g_bad_step
      $error("tsc_top: STEP_W must lie in 1..16");
   end
   if (RST_FAST >= (1 << STEP_W) || RST_SLOW >= (1 << STEP_W)) begin : g_bad_rst
      $error("tsc_top: reset steps do not fit STEP_W");
   end

   logic              run_en, snap_req, apply_req;
   logic [STEP_W-1:0] step_fast, step_slow;
   logic [CNT_W-1:0]  load_val, cnt_q;

   tsc_regs #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .STEP_W(STEP_W),
      .RST_FAST(RST_FAST), .RST_SLOW(RST_SLOW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .run_en(run_en), .snap_req(snap_req),
      .apply_req(apply_req), .step_fast(step_fast), .step_slow(step_slow),
      .load_val(load_val)
   );

   tsc_count #(
      .CNT_W(CNT_W), .STEP_W(STEP_W), .SPLIT_ADD(SPLIT_ADD)
   ) u_count (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_slow(src_slow),
      .step_fast(step_fast), .step_slow(step_slow), .apply_req(apply_req),
      .load_val(load_val), .cnt(cnt_q)
   );

   tsc_snap #(
      .CNT_W(CNT_W), .DATA_W(DATA_W)
   ) u_snap (
      .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .cnt(cnt_q),
      .snap_lo(snap_lo), .snap_hi(snap_hi), .snap_valid(snap_valid)
   );
endmodule

// File: rtl/tsc_chk.sv
module tsc_chk #(
   parameter int CNT_W  = 64,
   parameter int STEP_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run_en,
   input logic              src_slow,
   input logic              snap_req,
   input logic              apply_req,
   input logic [STEP_W-1:0] step_fast,
   input logic [STEP_W-1:0] step_slow,
   input logic [CNT_W-1:0]  load_val,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [31:0]       snap_lo,
   input logic [31:0]       snap_hi,
   input logic              snap_valid
);
   localparam int PAD_W = CNT_W - STEP_W;

   a_r3_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply_req && run_en && !src_slow) |=>
      cnt_q == $past(cnt_q) + {{PAD_W{1'b0}}, $past(step_fast)});

   a_r4_slow_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply_req && run_en && src_slow) |=>
      cnt_q == $past(cnt_q) + {{PAD_W{1'b0}}, $past(step_slow)});

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!apply_req && !run_en) |=> $stable(cnt_q));

   a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> {snap_hi, snap_lo} == $past(cnt_q));

   a_r8_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> !snap_valid);

   a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req ##1 !snap_req |=> snap_valid);

   a_r9_snap_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> ($stable(snap_lo) && $stable(snap_hi)));

   a_r10_apply_exact: assert property (@(posedge clk) disable iff (!rst_n)
      apply_req |=> cnt_q == $past(load_val));
endmodule

bind tsc_top tsc_chk #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_slow(src_slow),
   .snap_req(snap_req), .apply_req(apply_req), .step_fast(step_fast),
   .step_slow(step_slow), .load_val(load_val), .cnt_q(cnt_q),
   .snap_lo(snap_lo), .snap_hi(snap_hi), .snap_valid(snap_valid)
);

// File: tb/tb_tsc_top.sv
module tb_tsc_top;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        src_slow = 1'b0;
   logic [31:0] snap_lo, snap_hi;
   logic        snap_valid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   logic [63:0] m_cnt, m_ld, m_snap;
   logic [9:0]  m_fast, m_slow;
   bit          m_run, m_pend, m_val;

   tsc_top dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .src_slow(src_slow), .snap_lo(snap_lo),
      .snap_hi(snap_hi), .snap_valid(snap_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_ld = 0; m_snap = 0; m_fast = 1; m_slow = 2;
         m_run = 0; m_pend = 0; m_val = 0;
      end else begin
         bit snap, apply;
         logic [63:0] step;
         snap  = wr_en && wr_addr == 2'd0 && wr_data[1];
         apply = wr_en && wr_addr == 2'd0 && wr_data[2];
         step  = {54'd0, src_slow ? m_slow : m_fast};
         m_val  = !snap && (m_pend || m_val);
         m_pend = snap;
         if (snap) m_snap = m_cnt;
         if (apply) m_cnt = m_ld;
         else if (m_run) m_cnt = m_cnt + step;
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_run = wr_data[0];
               2'd1: begin m_fast = wr_data[9:0]; m_slow = wr_data[25:16]; end
               2'd2: m_ld[31:0] = wr_data;
               default: m_ld[63:32] = wr_data;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if ({snap_hi, snap_lo} !== m_snap || snap_valid !== m_val) begin
            n_bad++;
            $display("FAIL %s: snap=%h valid=%b expected snap=%h valid=%b",
                     cur_req, {snap_hi, snap_lo}, snap_valid, m_snap, m_val);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_valid();
      for (int i = 0; i < 8 && !snap_valid; i++) @(negedge clk);
   endtask

   task automatic check64(input string tag, input logic [63:0] exp);
      n_cmp++;
      if ({snap_hi, snap_lo} !== exp || snap_valid !== 1'b1) begin
         n_bad++;
         $display("FAIL %s: snap=%h valid=%b expected %h valid=1",
                  tag, {snap_hi, snap_lo}, snap_valid, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      n_cmp++;
      if (snap_valid !== 1'b0 || {snap_hi, snap_lo} !== 64'd0) begin
         n_bad++;
         $display("FAIL R1: snap=%h valid=%b expected 0 valid=0", {snap_hi, snap_lo}, snap_valid);
      end
      // R1/R5: disabled after reset, count stays 0
      wr(2'd0, 32'h2); wait_valid();
      check64("R1 R5 reset count", 64'd0);
      // R3: default fast step 1; run set then snapshot after one counting edge
      cur_req = "R3";
      wr(2'd0, 32'h1);
      wr(2'd0, 32'h3); wait_valid();
      check64("R3 default fast step", 64'd1);
      idle(5);
      wr(2'd0, 32'h3); wait_valid();
      // R4: slow source with default step 2
      cur_req = "R4";
      src_slow = 1'b1;
      idle(7);
      wr(2'd0, 32'h3); wait_valid();
      // R6: new step fields
      cur_req = "R6";
      wr(2'd1, (32'd7 << 16) | 32'd5);
      idle(4);
      wr(2'd0, 32'h3); wait_valid();
      src_slow = 1'b0;
      idle(3);
      wr(2'd0, 32'h3); wait_valid();
      // R8/R9: back-to-back requests and quiet stretch
      cur_req = "R8";
      wr(2'd0, 32'h3);
      wr(2'd0, 32'h3);
      cur_req = "R9";
      idle(10);
      // R5: stop and confirm hold
      cur_req = "R5";
      wr(2'd0, 32'h2); wait_valid();
      idle(6);
      wr(2'd0, 32'h2); wait_valid();
      // R10: staging without apply has no effect
      cur_req = "R10";
      wr(2'd2, 32'h2345_6789);
      wr(2'd3, 32'h0000_0001);
      idle(3);
      wr(2'd0, 32'h2); wait_valid();
      // R10: apply while stopped gives the exact value
      wr(2'd0, 32'h4);
      wr(2'd0, 32'h2); wait_valid();
      check64("R10 apply exact", 64'h0000_0001_2345_6789);
      // R10: apply with run, step 3; one counting edge before snapshot
      wr(2'd1, (32'd7 << 16) | 32'd3);
      wr(2'd0, 32'h5);
      wr(2'd0, 32'h3); wait_valid();
      check64("R10 apply beats step", 64'h0000_0001_2345_678C);
      // R11: wrap through 2^64
      cur_req = "R11";
      wr(2'd2, 32'hFFFF_FFFE);
      wr(2'd3, 32'hFFFF_FFFF);
      wr(2'd0, 32'h5);
      wr(2'd0, 32'h3); wait_valid();
      check64("R11 wrap", 64'd1);
      // R2: control write with no request bits changes nothing in snapshot
      cur_req = "R2";
      wr(2'd0, 32'h1);
      idle(4);
      wr(2'd0, 32'h3); wait_valid();
      idle(3);
      finish_run();
   end
endmodule